// File: doc/BRIEF.md
# I2C Bit-Phase Timing Generator

This block produces the clock phases for an I2C master, counted in cycles of the peripheral clock. Software chooses one of two speed modes and sets one high count and one low count for each mode. It also sets an 8-bit data setup count and an 8-bit data hold count, and the hold count has its own enable. While enabled, the block drives a generated SCL level. It raises a one-cycle strobe at the start of each SCL low phase and at the start of each SCL high phase. It also raises an SDA launch strobe that marks the cycle in which the bit engine may change SDA after the falling edge.

The whole configuration is captured in the cycle the enable is first seen. Changes to the inputs while the block runs are ignored until the enable is dropped and raised again. Short counts are raised to fixed minimums. The high phase carries a fixed extra latency of `HIGH_EXTRA` cycles. When the hold delay and the setup window conflict, the setup window wins: the launch point is pulled earlier so the data is still stable for the setup time before SCL rises.

Top module: `i2c_scl_timing`

## Requirements
- R1: With `en` low, and from reset, `scl` is 1 and `scl_rise`, `scl_fall` and `sda_launch` are 0.
- R2: When `fast_sel`=1 and `std_sel`=0, the fast count pair is used. In every other combination, including both set, the standard pair is used.
- R3: Each SCL high phase lasts max(high count, 6) + `HIGH_EXTRA` cycles (default 8).
- R4: Each SCL low phase lasts max(low count, 8) + 1 cycles.
- R5: The cycle after `en` is first sampled high is the first cycle of a low phase. `scl_fall` is 1 in the first cycle of every low phase, and `scl_rise` is 1 in the first cycle of every high phase.
- R6: With `hold_cfg[8]`=1, `sda_launch` is 1 in the low-phase cycle whose index (0 = the `scl_fall` cycle) is `hold_cfg[7:0]`+1, unless R8 limits it. It is 1 exactly once per low phase and never while `scl` is high.
- R7: With `hold_cfg[8]`=0, no hold delay is inserted: `sda_launch` is 1 in the same cycle as `scl_fall`.
- R8: The setup count S is taken as 1 when 0 is programmed (range 1 to 255). For a low phase of length Lo, the launch index is limited to min(Lo-1, max(Lo+1-S, 0)), so the data stays stable for S-1 cycles before SCL rises.
- R9: Changes to the mode selects, counts, setup or hold inputs while enabled have no effect until the next rising of `en`.
- R10: In the cycle after `en` is sampled low, `scl` is 1 and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; the configuration is captured when it is first seen high |
| std_sel | input | 1 | Standard-speed select |
| fast_sel | input | 1 | Fast-speed select (used only when `std_sel` is 0) |
| std_high | input | CNT_W | Standard-mode high count |
| std_low | input | CNT_W | Standard-mode low count |
| fast_high | input | CNT_W | Fast-mode high count |
| fast_low | input | CNT_W | Fast-mode low count |
| setup_cnt | input | 8 | SDA setup count (effective setup = count - 1 cycles) |
| hold_cfg | input | 9 | [8] hold enable, [7:0] hold count (effective hold = count + 1 cycles) |
| scl | output | 1 | Generated SCL level |
| scl_rise | output | 1 | First cycle of each high phase |
| scl_fall | output | 1 | First cycle of each low phase |
| sda_launch | output | 1 | Cycle in which SDA may change |

## Verification
Two functions can fall in the same cycle. The SDA launch can coincide with the SCL falling strobe, either because the hold is disabled or because a large setup count squeezes the launch index down to zero. The launch can also be pushed to the last low cycle, next to the rise. The bench provokes these cases with directed configurations: hold disabled, a setup count of 255 against a short low phase, and a hold of 200 against a short low phase. Random configurations cover the rest. Each case is judged cycle by cycle against a bench model of the phase lengths and the clamped launch index.

// File: rtl/i2ct_pkg.sv
// Shared types and constants for the I2C bit-phase timing generator.
// Assumes counts are unsigned cycle numbers of the peripheral clock.
package i2ct_pkg;
    typedef enum logic {MODE_STD = 1'b0, MODE_FAST = 1'b1} speed_e;
    localparam int unsigned HIGH_MIN = 6;   // floor applied to any high count
    localparam int unsigned LOW_MIN  = 8;   // floor applied to any low count
endpackage

// File: rtl/i2ct_cfg_latch.sv
// Configuration snapshot: resolves the speed mode, applies count minimums,
// derives the phase lengths and the clamped SDA launch index, and registers
// them when load is pulsed. Assumes load is a one-cycle start pulse.
module i2ct_cfg_latch
    import i2ct_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int HIGH_EXTRA = 8,
    localparam int LEN_W     = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             std_sel,
    input  logic             fast_sel,
    input  logic [CNT_W-1:0] std_high,
    input  logic [CNT_W-1:0] std_low,
    input  logic [CNT_W-1:0] fast_high,
    input  logic [CNT_W-1:0] fast_low,
    input  logic [7:0]       setup_cnt,
    input  logic [8:0]       hold_cfg,
    output logic [LEN_W-1:0] hi_len,
    output logic [LEN_W-1:0] lo_len,
    output logic [LEN_W-1:0] launch_at
);
    speed_e           mode;
    logic [LEN_W-1:0] h_raw, l_raw, hi_n, lo_n, s_eff, hd, cap, lim, launch_n;

    // Resolve the mode, the floors and the hold/setup launch index.
    always_comb begin
        mode  = (fast_sel && !std_sel) ? MODE_FAST : MODE_STD;
        h_raw = (mode == MODE_FAST) ? LEN_W'(fast_high) : LEN_W'(std_high);
        l_raw = (mode == MODE_FAST) ? LEN_W'(fast_low)  : LEN_W'(std_low);
        hi_n  = ((h_raw < LEN_W'(HIGH_MIN)) ? LEN_W'(HIGH_MIN) : h_raw) + LEN_W'(HIGH_EXTRA);
        lo_n  = ((l_raw < LEN_W'(LOW_MIN))  ? LEN_W'(LOW_MIN)  : l_raw) + LEN_W'(1);
        s_eff = (setup_cnt == 8'd0) ? LEN_W'(1) : LEN_W'(setup_cnt);
        hd    = hold_cfg[8] ? LEN_W'(hold_cfg[7:0]) + LEN_W'(1) : '0;
        cap   = ((lo_n + LEN_W'(1)) > s_eff) ? (lo_n + LEN_W'(1) - s_eff) : '0;
        lim   = (cap < (lo_n - LEN_W'(1))) ? cap : (lo_n - LEN_W'(1));
        launch_n = (hd < lim) ? hd : lim;
    end

    // Capture the derived timing at the start of a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len    <= LEN_W'(HIGH_MIN + HIGH_EXTRA);
            lo_len    <= LEN_W'(LOW_MIN + 1);
            launch_at <= '0;
        end else if (load) begin
            hi_len    <= hi_n;
            lo_len    <= lo_n;
            launch_at <= launch_n;
        end
    end

    p_hi_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_len >= LEN_W'(HIGH_MIN + HIGH_EXTRA));
    p_lo_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_len >= LEN_W'(LOW_MIN + 1));
    p_launch_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        launch_at < lo_len);
endmodule

// File: rtl/i2ct_phase_ctr.sv
// Phase counter: alternates SCL low and high phases of the latched lengths,
// starting with a low phase one cycle after enable is seen. Assumes the
// lengths are loaded on the same edge as the start.
module i2ct_phase_ctr #(
    parameter int LEN_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [LEN_W-1:0] hi_len,
    input  logic [LEN_W-1:0] lo_len,
    output logic             running,
    output logic             scl,
    output logic [LEN_W-1:0] cnt
);
    logic [LEN_W-1:0] last_idx;

    // Index of the final cycle of the current phase.
    always_comb last_idx = (scl ? hi_len : lo_len) - LEN_W'(1);

    // Start, count, reload at the phase boundary, or park with SCL high.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            running <= 1'b0;
            scl     <= 1'b1;
            cnt     <= '0;
        end else if (!running) begin
            running <= 1'b1;
            scl     <= 1'b0;
            cnt     <= '0;
        end else if (cnt == last_idx) begin
            scl <= ~scl;
            cnt <= '0;
        end else begin
            cnt <= cnt + LEN_W'(1);
        end
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < (scl ? hi_len : lo_len)));
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (scl && cnt == '0));
endmodule

// File: rtl/i2c_scl_timing.sv
// Top of the I2C bit-phase timing generator: snapshots the configuration on
// enable, runs the phase counter and decodes the rise, fall and SDA launch
// strobes. Assumes configuration inputs are stable around the enable edge.
module i2c_scl_timing #(
    parameter int CNT_W      = 16,
    parameter int HIGH_EXTRA = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             std_sel,
    input  logic             fast_sel,
    input  logic [CNT_W-1:0] std_high,
    input  logic [CNT_W-1:0] std_low,
    input  logic [CNT_W-1:0] fast_high,
    input  logic [CNT_W-1:0] fast_low,
    input  logic [7:0]       setup_cnt,
    input  logic [8:0]       hold_cfg,
    output logic             scl,
    output logic             scl_rise,
    output logic             scl_fall,
    output logic             sda_launch
);
    localparam int LEN_W = CNT_W + 2;

    logic             running, start;
    logic [LEN_W-1:0] hi_len, lo_len, launch_at, cnt;

    // A run starts on the first cycle enable is seen while idle.
    always_comb start = en && !running;

    i2ct_cfg_latch #(.CNT_W(CNT_W), .HIGH_EXTRA(HIGH_EXTRA)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(start),
        .std_sel(std_sel), .fast_sel(fast_sel),
        .std_high(std_high), .std_low(std_low),
        .fast_high(fast_high), .fast_low(fast_low),
        .setup_cnt(setup_cnt), .hold_cfg(hold_cfg),
        .hi_len(hi_len), .lo_len(lo_len), .launch_at(launch_at)
    );

    i2ct_phase_ctr #(.LEN_W(LEN_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .en(en),
        .hi_len(hi_len), .lo_len(lo_len),
        .running(running), .scl(scl), .cnt(cnt)
    );

    // Decode the per-phase strobes from the counter position.
    always_comb begin
        scl_fall   = running && !scl && (cnt == '0);
        scl_rise   = running &&  scl && (cnt == '0);
        sda_launch = running && !scl && (cnt == launch_at);
    end

    p_launch_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_launch |-> !scl);
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |->
            ($stable(hi_len) && $stable(lo_len) && $stable(launch_at)));
    p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> (scl && !scl_rise && !scl_fall && !sda_launch));
    p_fall_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> scl_fall);
endmodule

// File: tb/i2c_scl_timing_test.sv
module i2c_scl_timing_test;
    localparam int HX = 8;

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
    logic std_sel = 1'b1, fast_sel = 1'b0;
    logic [15:0] std_high = '0, std_low = '0, fast_high = '0, fast_low = '0;
    logic [7:0]  setup_cnt = '0;
    logic [8:0]  hold_cfg = '0;
    logic scl, scl_rise, scl_fall, sda_launch;

    int total = 0, bad = 0;
    int e_hi, e_lo, e_la;

    always #4 clk = ~clk;

    i2c_scl_timing uut (
        .clk(clk), .rst_n(rst_n), .en(en), .std_sel(std_sel), .fast_sel(fast_sel),
        .std_high(std_high), .std_low(std_low), .fast_high(fast_high), .fast_low(fast_low),
        .setup_cnt(setup_cnt), .hold_cfg(hold_cfg),
        .scl(scl), .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_launch(sda_launch)
    );

    // Expected lengths and launch index from the current inputs (R2 R3 R4 R6 R7 R8).
    task automatic calc();
        int h, l, s, hd, cap, lim;
        bit fast;
        fast = fast_sel && !std_sel;
        h = fast ? int'(fast_high) : int'(std_high);
        l = fast ? int'(fast_low)  : int'(std_low);
        e_hi = ((h < 6) ? 6 : h) + HX;
        e_lo = ((l < 8) ? 8 : l) + 1;
        s = (setup_cnt == 0) ? 1 : int'(setup_cnt);
        hd = hold_cfg[8] ? int'(hold_cfg[7:0]) + 1 : 0;
        cap = (e_lo + 1 > s) ? e_lo + 1 - s : 0;
        lim = (cap < e_lo - 1) ? cap : e_lo - 1;
        e_la = (hd < lim) ? hd : lim;
    endtask

    task automatic chk(input bit es, input bit er, input bit ef, input bit el, input string tag);
        total++;
        if ({scl, scl_rise, scl_fall, sda_launch} !== {es, er, ef, el}) begin
            bad++;
            $display("FAIL %s: scl/rise/fall/launch actual=%b expected=%b at %0t",
                     tag, {scl, scl_rise, scl_fall, sda_launch}, {es, er, ef, el}, $time);
        end
    endtask

    // Enable, then check nper full periods cycle by cycle; optionally
    // disturb the inputs after the first period (R9).
    task automatic run(input int nper, input bit mutate, input string tag);
        calc();
        @(negedge clk) en = 1'b1;
        for (int p = 0; p < nper; p++) begin
            for (int i = 0; i < e_lo; i++) begin
                @(negedge clk);
                chk(1'b0, 1'b0, i == 0, i == e_la, {tag, " R4 R5 R6 R8"});
                if (mutate && p == 1 && i == 0) begin
                    std_sel = ~std_sel; fast_sel = ~fast_sel;
                    std_high = 16'd40; std_low = 16'd41; fast_high = 16'd42; fast_low = 16'd43;
                    hold_cfg = 9'h103; setup_cnt = 8'd2;
                end
            end
            for (int i = 0; i < e_hi; i++) begin
                @(negedge clk);
                chk(1'b1, i == 0, 1'b0, 1'b0, {tag, " R3 R5 R9"});
            end
        end
        en = 1'b0;
        @(negedge clk);
        chk(1'b1, 1'b0, 1'b0, 1'b0, {tag, " R10"});
        repeat (2) begin
            @(negedge clk);
            chk(1'b1, 1'b0, 1'b0, 1'b0, {tag, " R1 idle"});
        end
    endtask

    task automatic cfg(input bit s, input bit f, input int sh, input int sl, input int fh,
                       input int fl, input int su, input int hc);
        std_sel = s; fast_sel = f;
        std_high = 16'(sh); std_low = 16'(sl); fast_high = 16'(fh); fast_low = 16'(fl);
        setup_cnt = 8'(su); hold_cfg = 9'(hc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(1'b1, 1'b0, 1'b0, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(1'b1, 1'b0, 1'b0, 1'b0, "R1 after reset");

        cfg(1, 0, 0, 0, 30, 30, 1, 9'h000);   run(2, 0, "R3 R4 minimums R7 hold off");
        cfg(0, 1, 30, 30, 10, 12, 3, 9'h102); run(2, 0, "R2 fast pair R6");
        cfg(1, 1, 11, 13, 6, 8, 2, 9'h101);   run(2, 0, "R2 both selects standard");
        cfg(0, 0, 9, 9, 20, 20, 2, 9'h100);   run(2, 0, "R2 neither select standard");
        cfg(1, 0, 7, 10, 0, 0, 255, 9'h105);  run(2, 0, "R8 launch squeezed to fall");
        cfg(1, 0, 7, 10, 0, 0, 0, 9'h1C8);    run(2, 0, "R8 large hold capped");
        cfg(1, 0, 7, 20, 0, 0, 4, 9'h1FF);    run(2, 0, "R8 hold vs setup");
        cfg(1, 0, 12, 15, 0, 0, 2, 9'h004);   run(3, 1, "R9 change ignored");
        run(2, 0, "R9 new config after re-enable");

        for (int k = 0; k < 25; k++) begin
            cfg($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 30),
                $urandom_range(0, 30), $urandom_range(0, 30), $urandom_range(0, 30),
                $urandom_range(0, 40), $urandom_range(0, 511));
            run(3, k[0], "random R2 R6 R7");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule